// File: doc/BRIEF.md
# Address Table Insert/Search Engine

This block owns a table of address entries, each 96 bits wide and kept as three 32-bit words, and serves one request at a time against it. There are four request kinds: add a unicast address, add a multicast group, delete an address, and find an address. For every request the engine walks the table from index 0 upwards, reading one entry per two cycles. It decodes each entry it reads back and remembers three candidate slots. These are the entry that already holds the requested MAC and VLAN, the lowest free entry, and the lowest entry that may be evicted. When the walk ends, it writes the new entry image through a table-control strobe, or it reports that no slot was found.

After reset the engine sweeps the table once and frees every entry. During that sweep it shows itself busy. A requester raises `req_valid` with the request fields while `busy` is low. It then waits for the one-cycle `done` pulse, which carries a status code, the chosen index and the entry image.

Top module: `addr_table_engine`

## Requirements
- R1: After reset, `busy` stays high for exactly DEPTH cycles while every entry is written free; `done` stays low. Afterwards a find of any address reports not-found.
- R2: A request is taken only in a cycle with `req_valid` high and `busy` low. A request offered while `busy` is high is ignored and produces no response and no table change. Each accepted request yields exactly one `done` pulse of one cycle, with `busy` low. Status codes are 0 ok, 1 not-found and 2 table-full. Op codes are 0 add-unicast, 1 add-multicast, 2 delete and 3 find.
- R3: The entry image is a 96-bit vector. Table word k holds bits 95−32k down to 64−32k. Bits 61:60 hold the kind: 0 free, 1 address, 2 VLAN, 3 VLAN-qualified address. Bits 59:48 hold the VLAN ID. Bits 47:0 hold the MAC, with the first transmitted byte in bits 47:40.
- R4: An entry matches a request when its kind is 1 or 3, its VLAN ID equals the request VID (0 when `req_vlan_en` is low), and all 48 MAC bits are equal.
- R5: An add picks its slot in this order: the matching entry, then the lowest-index free entry, then the lowest-index evictable entry. If none exists, it returns table-full with index 0 and a zero image, and it writes nothing.
- R6: An entry is evictable only if its kind is 1 or 3, bit 40 (multicast bit) is clear, and its 2-bit age class at bits 63:62 is 1 or 3. Class 0 (persistent) and class 2 (vendor-prefix) are never evicted.
- R7: An add-unicast writes the kind (3 if VLAN-qualified, else 1), the VLAN ID (0 if not qualified) and the MAC. It writes age class 0, or 1 when `req_dynamic` is set. It writes `req_secure` at bit 64, `req_blocked` at bit 65 and `req_port` at bits 66 upward (ceil(log2 PORTS) bits).
- R8: An add-multicast writes the kind, VLAN ID and MAC as in R7. It writes `req_super` at bit 65, `req_fwd_state` at bits 63:62 and the port mask at bits 66 upward (PORTS bits). On a match, the stored mask is ORed with `req_pmask`. Otherwise the mask is `req_pmask` alone.
- R9: A delete that matches writes an all-zero (free) entry and returns ok, with that index and a zero image. Without a match it returns not-found and the table is unchanged.
- R10: A find that matches returns ok with the index and the stored image, and writes nothing. Without a match it returns not-found with index 0 and a zero image.
- R11: The walk stops at the first match. A match at index k gives `done` 2k+3 cycles after the accepting clock edge. A walk with no match gives `done` 2·DEPTH+1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_op | input | 2 | Op code (R2) |
| req_mac | input | 48 | MAC address, first byte in bits 47:40 |
| req_vlan_en | input | 1 | Request is VLAN-qualified |
| req_vid | input | 12 | VLAN ID |
| req_port | input | PNW | Unicast destination port |
| req_secure | input | 1 | Unicast secure flag |
| req_blocked | input | 1 | Unicast blocked flag |
| req_dynamic | input | 1 | Unicast entry may be evicted later |
| req_pmask | input | PORTS | Multicast port mask |
| req_super | input | 1 | Multicast supervisory flag |
| req_fwd_state | input | 2 | Multicast forwarding state |
| busy | output | 1 | Sweep or walk in progress |
| done | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 ok, 1 not-found, 2 table-full |
| rsp_index | output | IW | Chosen or found index |
| rsp_entry | output | 96 | Written or found image |

## Verification
The bench targets the tier boundaries.

- A full table where the lowest evictable entry sits above a multicast entry and above a vendor-prefix entry. A design with a loose eviction test would overwrite the wrong slot.
- A table that still has free slots while a dynamic entry exists. A design with the tiers swapped would evict the dynamic entry instead of using a free slot.
- A second multicast add to an existing group. A design that overwrites instead of merging would lose the earlier port.
- A VLAN-qualified address searched both with and without its VLAN.
- A request offered mid-walk. A design that accepts it would produce a stray response or write the table.

Done latency is measured against the early-stop rule.

// File: rtl/ate_pkg.sv
package ate_pkg;
  localparam int ENTRY_W = 96;

  typedef enum logic [1:0] {
    OP_ADD_UC = 2'd0,
    OP_ADD_MC = 2'd1,
    OP_DEL    = 2'd2,
    OP_FIND   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOTFOUND = 2'd1,
    ST_FULL     = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    S_CLR, S_IDLE, S_RD, S_CHK, S_FIN
  } state_e;

  // entry kind values
  localparam logic [1:0] K_FREE  = 2'd0;
  localparam logic [1:0] K_ADDR  = 2'd1;
  localparam logic [1:0] K_VADDR = 2'd3;

  // field positions inside the 96-bit image
  localparam int KIND_LSB  = 60;
  localparam int VID_LSB   = 48;
  localparam int CLASS_LSB = 62;
  localparam int GRP_BIT   = 40;
  localparam int SEC_BIT   = 64;
  localparam int BLK_BIT   = 65;
  localparam int DEST_LSB  = 66;

  localparam logic [31:0] TC_WRITE = 32'h8000_0000;
endpackage

// File: rtl/ate_ram.sv
module ate_ram #(
  parameter int DEPTH = 1024,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        tc_we,
  input  logic [31:0] tc_val,
  input  logic [31:0] wd0,
  input  logic [31:0] wd1,
  input  logic [31:0] wd2,
  output logic [31:0] rd0,
  output logic [31:0] rd1,
  output logic [31:0] rd2
);
  logic [95:0]   mem [DEPTH];
  logic [95:0]   q;
  logic [IW-1:0] idx;
  logic          unused_hi;

  assign idx       = tc_val[IW-1:0];
  assign unused_hi = ^tc_val[30:IW];

  // bit 31 of the control word selects write, clear selects read
  always_ff @(posedge clk) begin
    if (tc_we && tc_val[31]) mem[idx] <= {wd0, wd1, wd2};
    if (tc_we && !tc_val[31]) q <= mem[idx];
  end

  assign rd0 = q[95:64];
  assign rd1 = q[63:32];
  assign rd2 = q[31:0];
endmodule

// File: rtl/ate_decode.sv
module ate_decode
  import ate_pkg::*;
(
  input  logic [95:0] ent,
  input  logic [47:0] key_mac,
  input  logic [11:0] key_vid,
  output logic        is_free,
  output logic        is_match,
  output logic        is_evict
);
  logic [1:0] kind;
  logic [1:0] age_cls;
  logic       addr_kind;
  logic       unused_top;

  assign kind       = ent[KIND_LSB +: 2];
  assign age_cls    = ent[CLASS_LSB +: 2];
  assign addr_kind  = (kind == K_ADDR) || (kind == K_VADDR);
  assign unused_top = ^ent[95:64];

  assign is_free  = (kind == K_FREE);
  assign is_match = addr_kind && (ent[VID_LSB +: 12] == key_vid)
                    && (ent[47:0] == key_mac);
  // age classes 0 and 2 are pinned; only 1 and 3 may be replaced
  assign is_evict = addr_kind && !ent[GRP_BIT] && age_cls[0];
endmodule

// File: rtl/ate_image.sv
module ate_image
  import ate_pkg::*;
#(
  parameter int PORTS = 3,
  localparam int PNW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  op_e              op,
  input  logic [95:0]      base,
  input  logic             have_base,
  input  logic [47:0]      mac,
  input  logic             ven,
  input  logic [11:0]      vid,
  input  logic [PNW-1:0]   port,
  input  logic             sec,
  input  logic             blk,
  input  logic             dyn,
  input  logic [PORTS-1:0] pmask,
  input  logic             sup,
  input  logic [1:0]       fwd,
  output logic [95:0]      img
);
  always_comb begin
    img = '0;
    unique case (op)
      OP_ADD_UC: begin
        img[KIND_LSB +: 2]  = ven ? K_VADDR : K_ADDR;
        img[VID_LSB +: 12]  = vid;
        img[47:0]           = mac;
        img[CLASS_LSB +: 2] = dyn ? 2'd1 : 2'd0;
        img[SEC_BIT]        = sec;
        img[BLK_BIT]        = blk;
        img[DEST_LSB +: PNW] = port;
      end
      OP_ADD_MC: begin
        img = have_base ? base : '0;
        img[KIND_LSB +: 2]  = ven ? K_VADDR : K_ADDR;
        img[VID_LSB +: 12]  = vid;
        img[47:0]           = mac;
        img[CLASS_LSB +: 2] = fwd;
        img[BLK_BIT]        = sup;
        img[DEST_LSB +: PORTS] =
          (have_base ? base[DEST_LSB +: PORTS] : '0) | pmask;
      end
      default: img = '0;
    endcase
  end
endmodule

// File: rtl/addr_table_engine.sv
module addr_table_engine
  import ate_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PORTS = 3,
  localparam int IW  = $clog2(DEPTH),
  localparam int PNW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [47:0]      req_mac,
  input  logic             req_vlan_en,
  input  logic [11:0]      req_vid,
  input  logic [PNW-1:0]   req_port,
  input  logic             req_secure,
  input  logic             req_blocked,
  input  logic             req_dynamic,
  input  logic [PORTS-1:0] req_pmask,
  input  logic             req_super,
  input  logic [1:0]       req_fwd_state,
  output logic             busy,
  output logic             done,
  output logic [1:0]       rsp_status,
  output logic [IW-1:0]    rsp_index,
  output logic [95:0]      rsp_entry
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  state_e state, state_n;
  logic [IW-1:0] scan_idx, match_idx, free_idx, evict_idx, slot;
  logic has_match, has_free, has_evict, slot_ok, do_wr;
  logic [95:0] match_ent, img, wdata, rdata;
  logic tc_we;
  logic [31:0] tc_val;
  logic dec_free, dec_match, dec_evict;

  // latched request
  op_e              r_op;
  logic [47:0]      r_mac;
  logic             r_ven, r_sec, r_blk, r_dyn, r_sup;
  logic [11:0]      r_vid;
  logic [PNW-1:0]   r_port;
  logic [PORTS-1:0] r_pmask;
  logic [1:0]       r_fwd;

  ate_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .tc_we(tc_we), .tc_val(tc_val),
    .wd0(wdata[95:64]), .wd1(wdata[63:32]), .wd2(wdata[31:0]),
    .rd0(rdata[95:64]), .rd1(rdata[63:32]), .rd2(rdata[31:0])
  );

  ate_decode u_dec (
    .ent(rdata), .key_mac(r_mac), .key_vid(r_vid),
    .is_free(dec_free), .is_match(dec_match), .is_evict(dec_evict)
  );

  ate_image #(.PORTS(PORTS)) u_img (
    .op(r_op), .base(match_ent), .have_base(has_match), .mac(r_mac),
    .ven(r_ven), .vid(r_vid), .port(r_port), .sec(r_sec), .blk(r_blk),
    .dyn(r_dyn), .pmask(r_pmask), .sup(r_sup), .fwd(r_fwd), .img(img)
  );

  // slot choice: match, then free, then evictable
  always_comb begin
    slot_ok = 1'b0;
    slot    = match_idx;
    if (r_op == OP_FIND || r_op == OP_DEL) begin
      slot_ok = has_match;
    end else if (has_match) begin
      slot_ok = 1'b1;
    end else if (has_free) begin
      slot_ok = 1'b1;
      slot    = free_idx;
    end else if (has_evict) begin
      slot_ok = 1'b1;
      slot    = evict_idx;
    end
    do_wr = slot_ok && (r_op != OP_FIND);
  end

  // table-control port
  always_comb begin
    tc_we  = 1'b0;
    tc_val = '0;
    wdata  = '0;
    unique case (state)
      S_CLR: begin
        tc_we  = 1'b1;
        tc_val = TC_WRITE | 32'(scan_idx);
      end
      S_RD: begin
        tc_we  = 1'b1;
        tc_val = 32'(scan_idx);
      end
      S_FIN: if (do_wr) begin
        tc_we  = 1'b1;
        tc_val = TC_WRITE | 32'(slot);
        wdata  = img;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      S_CLR:  if (scan_idx == LAST) state_n = S_IDLE;
      S_IDLE: if (req_valid) state_n = S_RD;
      S_RD:   state_n = S_CHK;
      S_CHK:  state_n = (dec_match || scan_idx == LAST) ? S_FIN : S_RD;
      S_FIN:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_CLR;
      busy       <= 1'b1;
      done       <= 1'b0;
      scan_idx   <= '0;
      has_match  <= 1'b0;
      has_free   <= 1'b0;
      has_evict  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_index  <= '0;
      rsp_entry  <= '0;
    end else begin
      state <= state_n;
      busy  <= (state_n != S_IDLE);
      done  <= (state == S_FIN);
      unique case (state)
        S_CLR: scan_idx <= (scan_idx == LAST) ? '0 : scan_idx + 1'b1;
        S_IDLE: if (req_valid) begin
          r_op      <= op_e'(req_op);
          r_mac     <= req_mac;
          r_ven     <= req_vlan_en;
          r_vid     <= req_vlan_en ? req_vid : 12'd0;
          r_port    <= req_port;
          r_sec     <= req_secure;
          r_blk     <= req_blocked;
          r_dyn     <= req_dynamic;
          r_pmask   <= req_pmask;
          r_sup     <= req_super;
          r_fwd     <= req_fwd_state;
          scan_idx  <= '0;
          has_match <= 1'b0;
          has_free  <= 1'b0;
          has_evict <= 1'b0;
        end
        S_CHK: begin
          if (dec_match) begin
            has_match <= 1'b1;
            match_idx <= scan_idx;
            match_ent <= rdata;
          end else begin
            if (dec_free && !has_free) begin
              has_free <= 1'b1;
              free_idx <= scan_idx;
            end
            if (dec_evict && !has_evict) begin
              has_evict <= 1'b1;
              evict_idx <= scan_idx;
            end
            if (scan_idx != LAST) scan_idx <= scan_idx + 1'b1;
          end
        end
        S_FIN: begin
          rsp_status <= slot_ok ? ST_OK :
                        ((r_op == OP_FIND || r_op == OP_DEL) ? ST_NOTFOUND : ST_FULL);
          rsp_index  <= slot_ok ? slot : '0;
          rsp_entry  <= !slot_ok ? '0 : ((r_op == OP_FIND) ? match_ent : img);
        end
        default: ;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R5
  full_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_status == ST_FULL) |-> !$past(tc_we && tc_val[31]));
  // R11
  scan_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHK && dec_match) |=> (state == S_FIN));
endmodule

// File: tb/addr_table_engine_test.sv
`timescale 1ns/1ps
module addr_table_engine_test;
  localparam int D = 16;
  localparam int P = 3;
  localparam int FULL_LAT = 2 * D + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [47:0] req_mac = '0;
  logic req_vlan_en = 1'b0;
  logic [11:0] req_vid = '0;
  logic [1:0] req_port = '0;
  logic req_secure = 1'b0, req_blocked = 1'b0, req_dynamic = 1'b0, req_super = 1'b0;
  logic [P-1:0] req_pmask = '0;
  logic [1:0] req_fwd_state = '0;
  logic busy, done;
  logic [1:0] rsp_status;
  logic [3:0] rsp_index;
  logic [95:0] rsp_entry;

  always #2.5 clk = ~clk;

  addr_table_engine #(.DEPTH(D), .PORTS(P)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_mac(req_mac), .req_vlan_en(req_vlan_en), .req_vid(req_vid),
    .req_port(req_port), .req_secure(req_secure), .req_blocked(req_blocked),
    .req_dynamic(req_dynamic), .req_pmask(req_pmask), .req_super(req_super),
    .req_fwd_state(req_fwd_state), .busy(busy), .done(done),
    .rsp_status(rsp_status), .rsp_index(rsp_index), .rsp_entry(rsp_entry)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, acc = 0;
  bit finished = 0;
  logic [1:0]  q_st [$];
  int          q_idx [$];
  logic [95:0] q_ent [$];
  int          q_lat [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected images built from R3, R7 and R8
  function automatic logic [95:0] uc(input logic [47:0] mac, input logic ven,
      input logic [11:0] vid, input logic [1:0] port, input logic sec,
      input logic blk, input logic dyn);
    logic [95:0] e = '0;
    e[61:60] = ven ? 2'd3 : 2'd1;
    e[59:48] = ven ? vid : 12'd0;
    e[47:0]  = mac;
    e[63:62] = dyn ? 2'd1 : 2'd0;
    e[64] = sec;
    e[65] = blk;
    e[67:66] = port;
    return e;
  endfunction

  function automatic logic [95:0] mc(input logic [47:0] mac, input logic [2:0] pm,
      input logic sup, input logic [1:0] fs);
    logic [95:0] e = '0;
    e[61:60] = 2'd1;
    e[47:0]  = mac;
    e[63:62] = fs;
    e[65] = sup;
    e[68:66] = pm;
    return e;
  endfunction

  // monitor: pop one expectation per done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_st.size() == 0) begin
        chk(1'b0, "R2", "unexpected done", {94'd0, rsp_status}, '0);
      end else begin
        automatic logic [1:0]  est = q_st.pop_front();
        automatic int          eix = q_idx.pop_front();
        automatic logic [95:0] een = q_ent.pop_front();
        automatic int          elt = q_lat.pop_front();
        automatic string       tg  = q_tag.pop_front();
        chk(rsp_status == est, tg, "status", {94'd0, rsp_status}, {94'd0, est});
        chk(rsp_index == 4'(eix), tg, "index", {92'd0, rsp_index}, 96'(eix));
        chk(rsp_entry == een, tg, "entry", rsp_entry, een);
        if (elt >= 0)
          chk((cyc - acc) == elt, {tg, " R11"}, "latency", 96'(cyc - acc), 96'(elt));
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [47:0] mac,
      input logic ven, input logic [11:0] vid, input logic [1:0] port,
      input logic sec, input logic blk, input logic dyn, input logic [2:0] pm,
      input logic sup, input logic [1:0] fs, input logic [1:0] est,
      input int eix, input logic [95:0] een, input int elt, input string tag);
    q_st.push_back(est); q_idx.push_back(eix); q_ent.push_back(een);
    q_lat.push_back(elt); q_tag.push_back(tag);
    @(negedge clk);
    req_op = op; req_mac = mac; req_vlan_en = ven; req_vid = vid;
    req_port = port; req_secure = sec; req_blocked = blk; req_dynamic = dyn;
    req_pmask = pm; req_super = sup; req_fwd_state = fs;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic settle();
    wait (q_st.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [47:0] mac,
      input logic ven, input logic [11:0] vid, input logic [1:0] port,
      input logic sec, input logic blk, input logic dyn, input logic [2:0] pm,
      input logic sup, input logic [1:0] fs, input logic [1:0] est,
      input int eix, input logic [95:0] een, input int elt, input string tag);
    issue(op, mac, ven, vid, port, sec, blk, dyn, pm, sup, fs, est, eix, een, elt, tag);
    settle();
  endtask

  localparam logic [1:0] UC = 2'd0, MC = 2'd1, DL = 2'd2, FD = 2'd3;
  localparam logic [1:0] OK = 2'd0, NF = 2'd1, FL = 2'd2;
  localparam logic [47:0] MA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MB = 48'h02_aa_bb_cc_dd_01;
  localparam logic [47:0] MM = 48'h01_00_5e_00_00_07;
  localparam logic [47:0] MC_ = 48'h02_00_00_00_00_0c;
  localparam logic [47:0] MX = 48'h02_00_00_00_00_58;
  localparam logic [47:0] MY = 48'h02_00_00_00_00_59;
  localparam logic [47:0] MZ = 48'h02_00_00_00_00_5a;

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: sweep after reset
    chk(busy == 1'b1 && done == 1'b0, "R1", "busy during sweep", {94'd0, busy, done}, 96'd2);
    n = 0;
    while (busy && n < 10 * D) begin
      @(negedge clk);
      n++;
    end
    chk(n == D, "R1", "sweep length", 96'(n), 96'(D));

    // R1 R10: table empty; R2 request offered mid-walk must be ignored
    issue(FD, MA, 0, 0, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R1 R10");
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R2", "busy mid-walk", {95'd0, busy}, 96'd1);
    req_op = UC; req_mac = MZ; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    settle();

    send(UC, MA, 0, 0, 2, 1, 0, 0, 0, 0, 0, OK, 0, uc(MA, 0, 0, 2, 1, 0, 0), FULL_LAT, "R5 R7 R3");
    send(UC, MB, 1, 12'd5, 1, 0, 1, 1, 0, 0, 0, OK, 1, uc(MB, 1, 12'd5, 1, 0, 1, 1), FULL_LAT, "R7 R3");
    send(FD, MB, 0, 12'd5, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R4");
    send(FD, MB, 1, 12'd5, 0, 0, 0, 0, 0, 0, 0, OK, 1, uc(MB, 1, 12'd5, 1, 0, 1, 1), 5, "R10 R4");
    send(UC, MA, 0, 0, 1, 0, 0, 0, 0, 0, 0, OK, 0, uc(MA, 0, 0, 1, 0, 0, 0), 3, "R5 R4");
    send(MC, MM, 0, 0, 0, 0, 0, 0, 3'b001, 0, 2'd1, OK, 2, mc(MM, 3'b001, 0, 2'd1), FULL_LAT, "R8");
    send(MC, MM, 0, 0, 0, 0, 0, 0, 3'b100, 1, 2'd3, OK, 2, mc(MM, 3'b101, 1, 2'd3), 7, "R8");
    send(DL, MB, 1, 12'd5, 0, 0, 0, 0, 0, 0, 0, OK, 1, '0, 5, "R9");
    send(DL, MB, 1, 12'd5, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R9");
    send(UC, MC_, 0, 0, 0, 0, 0, 0, 0, 0, 0, OK, 1, uc(MC_, 0, 0, 0, 0, 0, 0), FULL_LAT, "R5");
    send(FD, MZ, 0, 0, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R2");

    // fill: slot 5 vendor-prefix class, slot 7 dynamic
    for (int i = 3; i < D; i++) begin
      automatic logic [47:0] fm = 48'h02_f0_00_00_00_00 + 48'(i);
      if (i == 5)
        send(MC, fm, 0, 0, 0, 0, 0, 0, 3'b010, 0, 2'd2, OK, i, mc(fm, 3'b010, 0, 2'd2), FULL_LAT, "R8 R5");
      else
        send(UC, fm, 0, 0, 1, 0, 0, (i == 7), 0, 0, 0, OK, i,
             uc(fm, 0, 0, 1, 0, 0, (i == 7)), FULL_LAT, "R5 R7");
    end

    send(UC, MX, 0, 0, 2, 0, 0, 0, 0, 0, 0, OK, 7, uc(MX, 0, 0, 2, 0, 0, 0), FULL_LAT, "R6 R5");
    send(UC, MY, 0, 0, 2, 0, 0, 0, 0, 0, 0, FL, 0, '0, FULL_LAT, "R5 R6");
    send(FD, MY, 0, 0, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R5");
    send(FD, MX, 0, 0, 0, 0, 0, 0, 0, 0, 0, OK, 7, uc(MX, 0, 0, 2, 0, 0, 0), 17, "R10 R6");
    send(FD, MM, 0, 0, 0, 0, 0, 0, 0, 0, 0, OK, 2, mc(MM, 3'b101, 1, 2'd3), 7, "R6 R10");
    send(DL, MY, 0, 0, 0, 0, 0, 0, 0, 0, 0, NF, 0, '0, FULL_LAT, "R9");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule